// File: doc/BRIEF.md
# GPIO Bank Interrupt Sense Controller

This block watches one bank of general-purpose pins, whose inputs are already synchronized and filtered, and turns pin activity into interrupts. Each pin has its own sense mode, chosen by three per-pin configuration bits. The mode can be falling edge, rising edge, both edges, low level or high level. A detected event latches into a per-pin pending bit. Software clears that bit by writing a one to it.

A per-pin enable register gates which pending bits reach the single summary interrupt line. Pending bits are recorded whether or not their pin is enabled. A parameter lists the pins that can act as inputs, and the remaining pins never raise a pending bit.

Software reaches the registers through a simple word-wide port. Writes are single-cycle, and a read returns the addressed register combinationally.

Top module: `gpio_irq_sense`

## Requirements
- R1: Registers sit at byte addresses 0x00 (enable), 0x04 (sense bit A), 0x08 (sense bit B), 0x0C (sense bit C) and 0x10 (pending). Enable and the three sense registers read back what was written. Any other address reads zero and ignores writes.
- R2: With B=0 and A=0 on a pin, a high-to-low change of that pin sets its pending bit at the first clock edge that sees the new value. A low-to-high change sets nothing.
- R3: With B=0, A=1 and C=0, a low-to-high change sets the pending bit. A high-to-low change does not.
- R4: With B=0, A=1 and C=1, both kinds of change set the pending bit. With A=0, the C bit has no effect and the pin senses falling edges only.
- R5: With B=1, the pin is level-sensitive: A=1 means active high and A=0 means active low. The pending bit is set on every clock edge where the active level is present, so a clear cannot remove it while that level persists.
- R6: Writing 1 to a pending bit clears it on that clock edge. Writing 0 leaves it unchanged. A pending bit otherwise holds until cleared.
- R7: When a clear and a new event hit the same pending bit on the same clock edge, the bit stays set.
- R8: `irq_out` is a register loaded each clock with the OR over all pins of pending AND enable. It therefore follows the pending and enable state one clock later. A pending bit on a disabled pin does not raise it.
- R9: Pins whose bit in parameter INPUT_PINS is 0 never set a pending bit, in any sense mode.
- R10: After reset, all registers read zero and `irq_out` is low. Pins held steady through and after reset set no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | AW (5) | Byte address of the register |
| reg_wdata | input | NPINS (32) | Write data, one bit per pin |
| reg_rdata | output | NPINS (32) | Read data for `reg_addr`, combinational |
| pin_in | input | NPINS (32) | Synchronized pin levels |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
A pin change presented between clock edges shows in the pending register just after the next rising edge. `irq_out` reflects that pending bit one edge later. A register write becomes visible on read-back after the edge that takes it, and an enable write reaches `irq_out` one edge after that. The bench changes inputs on the falling edge and samples on the following falling edge, stepping one more falling edge for every extra register stage. It also checks `irq_out` at the intermediate edge, to confirm the one-cycle lag rather than merely the final value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [4:0] OFS_ENABLE  = 5'h00;
  localparam logic [4:0] OFS_SENSE_A = 5'h04;
  localparam logic [4:0] OFS_SENSE_B = 5'h08;
  localparam logic [4:0] OFS_SENSE_C = 5'h0C;
  localparam logic [4:0] OFS_PENDING = 5'h10;

  typedef enum logic [2:0] {
    SENSE_FALL = 3'd0,
    SENSE_RISE = 3'd1,
    SENSE_BOTH = 3'd2,
    SENSE_LOW  = 3'd3,
    SENSE_HIGH = 3'd4
  } sense_e;

  // b selects level vs edge, a selects polarity, c widens rising to both edges
  function automatic sense_e decode_sense(input logic a, input logic b, input logic c);
    sense_e m;
    if (b) begin
      m = a ? SENSE_HIGH : SENSE_LOW;
    end else if (a) begin
      m = c ? SENSE_BOTH : SENSE_RISE;
    end else begin
      m = SENSE_FALL;
    end
    return m;
  endfunction

endpackage

// File: rtl/girq_regfile.sv
module girq_regfile
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  input  logic [NPINS-1:0] pending,
  output logic [NPINS-1:0] enable_q,
  output logic [NPINS-1:0] sense_a_q,
  output logic [NPINS-1:0] sense_b_q,
  output logic [NPINS-1:0] sense_c_q,
  output logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] reg_rdata
);

  localparam logic [AW-1:0] A_EN  = AW'(OFS_ENABLE);
  localparam logic [AW-1:0] A_SA  = AW'(OFS_SENSE_A);
  localparam logic [AW-1:0] A_SB  = AW'(OFS_SENSE_B);
  localparam logic [AW-1:0] A_SC  = AW'(OFS_SENSE_C);
  localparam logic [AW-1:0] A_PND = AW'(OFS_PENDING);

  logic ld_en, ld_sa, ld_sb, ld_sc;
  logic [NPINS-1:0] enable_d, sense_a_d, sense_b_d, sense_c_d;

  always_comb begin
    ld_en    = reg_wr && (reg_addr == A_EN);
    ld_sa    = reg_wr && (reg_addr == A_SA);
    ld_sb    = reg_wr && (reg_addr == A_SB);
    ld_sc    = reg_wr && (reg_addr == A_SC);
    clr_mask = (reg_wr && (reg_addr == A_PND)) ? reg_wdata : '0;
    enable_d  = ld_en ? reg_wdata : enable_q;
    sense_a_d = ld_sa ? reg_wdata : sense_a_q;
    sense_b_d = ld_sb ? reg_wdata : sense_b_q;
    sense_c_d = ld_sc ? reg_wdata : sense_c_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q  <= '0;
      sense_a_q <= '0;
      sense_b_q <= '0;
      sense_c_q <= '0;
    end else begin
      if (ld_en) enable_q  <= enable_d;
      if (ld_sa) sense_a_q <= sense_a_d;
      if (ld_sb) sense_b_q <= sense_b_d;
      if (ld_sc) sense_c_q <= sense_c_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_EN:    reg_rdata = enable_q;
      A_SA:    reg_rdata = sense_a_q;
      A_SB:    reg_rdata = sense_b_q;
      A_SC:    reg_rdata = sense_c_q;
      A_PND:   reg_rdata = pending;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/girq_detect.sv
module girq_detect
  import gpio_irq_pkg::*;
#(
  parameter int               NPINS      = 32,
  parameter logic [NPINS-1:0] INPUT_PINS = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] sense_a,
  input  logic [NPINS-1:0] sense_b,
  input  logic [NPINS-1:0] sense_c,
  output logic [NPINS-1:0] event_hit
);

  logic [NPINS-1:0] pin_q;
  logic [NPINS-1:0] raw_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_in;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    sense_e mode;
    always_comb begin
      mode = decode_sense(sense_a[i], sense_b[i], sense_c[i]);
      unique case (mode)
        SENSE_FALL: raw_hit[i] = pin_q[i] & ~pin_in[i];
        SENSE_RISE: raw_hit[i] = ~pin_q[i] & pin_in[i];
        SENSE_BOTH: raw_hit[i] = pin_q[i] ^ pin_in[i];
        SENSE_LOW:  raw_hit[i] = ~pin_in[i];
        SENSE_HIGH: raw_hit[i] = pin_in[i];
        default:    raw_hit[i] = 1'b0;
      endcase
    end
  end

  assign event_hit = raw_hit & INPUT_PINS;

endmodule

// File: rtl/girq_pending.sv
module girq_pending #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] event_hit,
  input  logic [NPINS-1:0] clr_mask,
  input  logic [NPINS-1:0] enable,
  output logic [NPINS-1:0] pending_q,
  output logic             irq_q
);

  logic [NPINS-1:0] pending_d;
  logic             irq_d;

  always_comb begin
    pending_d = (pending_q & ~clr_mask) | event_hit;
    irq_d     = |(pending_q & enable);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      pending_q <= pending_d;
      irq_q     <= irq_d;
    end
  end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int               NPINS      = 32,
  parameter int               AW         = 5,
  parameter logic [NPINS-1:0] INPUT_PINS = 32'h0FFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic             irq_out
);

  logic [NPINS-1:0] enable_q, sense_a_q, sense_b_q, sense_c_q;
  logic [NPINS-1:0] clr_mask, event_hit, pending_q;

  girq_regfile #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pending(pending_q), .enable_q(enable_q),
    .sense_a_q(sense_a_q), .sense_b_q(sense_b_q), .sense_c_q(sense_c_q),
    .clr_mask(clr_mask), .reg_rdata(reg_rdata)
  );

  girq_detect #(.NPINS(NPINS), .INPUT_PINS(INPUT_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sense_a(sense_a_q),
    .sense_b(sense_b_q), .sense_c(sense_c_q), .event_hit(event_hit)
  );

  girq_pending #(.NPINS(NPINS)) u_pnd (
    .clk(clk), .rst_n(rst_n), .event_hit(event_hit), .clr_mask(clr_mask),
    .enable(enable_q), .pending_q(pending_q), .irq_q(irq_out)
  );

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
  parameter int               NPINS      = 32,
  parameter logic [NPINS-1:0] INPUT_PINS = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_out,
  input logic [NPINS-1:0] pending_q,
  input logic [NPINS-1:0] enable_q,
  input logic [NPINS-1:0] event_hit,
  input logic [NPINS-1:0] clr_mask
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_irq_lags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (irq_out == |($past(pending_q) & $past(enable_q))));

  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((pending_q & $past(clr_mask) & ~$past(event_hit)) == '0));

  assert_pending_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (($past(pending_q) & ~$past(clr_mask) & ~pending_q) == '0));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((pending_q & $past(event_hit)) == $past(event_hit)));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((pending_q & ~$past(pending_q) & ~$past(event_hit)) == '0));

  assert_incapable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q & ~INPUT_PINS) == '0);

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NPINS(NPINS), .INPUT_PINS(INPUT_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .pending_q(pending_q),
  .enable_q(enable_q), .event_hit(event_hit), .clr_mask(clr_mask)
);

// File: tb/test_gpio_irq_sense.sv
module test_gpio_irq_sense;

  localparam logic [4:0] EN = 5'h00, SA = 5'h04, SB = 5'h08, SC = 5'h0C, PND = 5'h10;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, pins;
  logic        irq_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_sense i_gpio_irq_sense (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pins), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk); pins = v;
    @(negedge clk);
  endtask

  task automatic prep(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                      input logic [31:0] base);
    wr(SA, a); wr(SB, b); wr(SC, c);
    set_pins(base);
    wr(PND, ONES);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(EN, v);  check("R10 enable after reset", v, 0);
    rd(SA, v);  check("R10 sense A after reset", v, 0);
    rd(PND, v); check("R10 pending after reset", v, 0);
    check("R10 irq after reset", {31'b0, irq_out}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(EN, 32'hA5A5_0F0F); wr(SA, 32'h1234_5678); wr(SB, 32'h0F0F_0001); wr(SC, 32'h8000_00FF);
    rd(EN, v); check("R1 enable readback", v, 32'hA5A5_0F0F);
    rd(SA, v); check("R1 sense A readback", v, 32'h1234_5678);
    rd(SB, v); check("R1 sense B readback", v, 32'h0F0F_0001);
    rd(SC, v); check("R1 sense C readback", v, 32'h8000_00FF);
    wr(5'h14, ONES);
    rd(5'h14, v); check("R1 unmapped reads zero", v, 0);
    rd(EN, v); check("R1 unmapped write ignored", v, 32'hA5A5_0F0F);
    wr(EN, 0); wr(SA, 0); wr(SB, 0); wr(SC, 0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    prep(0, 0, 0, ONES);
    rd(PND, v); check("R2 clean start", v, 0);
    set_pins(ONES & ~32'h20);
    rd(PND, v); check("R2 falling edge sets", v, 32'h20);
    wr(PND, ONES); set_pins(ONES);
    rd(PND, v); check("R2 rising ignored", v, 0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    prep(ONES, 0, 0, 0);
    set_pins(32'h80);
    rd(PND, v); check("R3 rising edge sets", v, 32'h80);
    wr(PND, ONES); set_pins(0);
    rd(PND, v); check("R3 falling ignored", v, 0);
  endtask

  task automatic t_both();
    logic [31:0] v;
    prep(ONES, 0, ONES, 0);
    set_pins(32'h200);
    rd(PND, v); check("R4 both: rise", v, 32'h200);
    wr(PND, ONES); set_pins(0);
    rd(PND, v); check("R4 both: fall", v, 32'h200);
    prep(0, 0, ONES, 0);
    set_pins(32'h200);
    rd(PND, v); check("R4 C ignored when A=0: rise", v, 0);
    set_pins(0);
    rd(PND, v); check("R4 C ignored when A=0: fall", v, 32'h200);
  endtask

  task automatic t_level();
    logic [31:0] v;
    prep(ONES, ONES, 0, 0);
    set_pins(32'h800);
    rd(PND, v); check("R5 level high sets", v, 32'h800);
    wr(PND, ONES);
    rd(PND, v); check("R5 level high resets after clear", v, 32'h800);
    set_pins(0); wr(PND, ONES);
    rd(PND, v); check("R5 level high gone", v, 0);
    set_pins(ONES); wr(SA, 0); wr(PND, ONES);
    rd(PND, v); check("R5 level low idle", v, 0);
    set_pins(ONES & ~32'h1000);
    rd(PND, v); check("R5 level low sets", v, 32'h1000);
    set_pins(ONES); wr(PND, ONES);
    rd(PND, v); check("R5 level low released", v, 0);
    wr(SB, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    prep(ONES, 0, 0, 0);
    set_pins(32'hE);
    rd(PND, v); check("R6 three pending", v, 32'hE);
    wr(PND, 0);
    rd(PND, v); check("R6 zero write no effect", v, 32'hE);
    wr(PND, 32'h4);
    rd(PND, v); check("R6 one clears one bit", v, 32'hA);
    wr(PND, ONES);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    prep(ONES, 0, 0, 0);
    set_pins(32'h8);
    @(negedge clk); pins = 32'h18; reg_wr = 1'b1; reg_addr = PND; reg_wdata = 32'h18;
    @(negedge clk); reg_wr = 1'b0;
    rd(PND, v); check("R7 event beats clear", v, 32'h10);
    wr(PND, ONES);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(EN, 0);
    prep(ONES, 0, 0, 0);
    set_pins(32'h40);
    @(negedge clk);
    check("R8 disabled pin quiet", {31'b0, irq_out}, 0);
    wr(EN, 32'h40);
    check("R8 irq one cycle after enable", {31'b0, irq_out}, 0);
    @(negedge clk);
    check("R8 irq raised", {31'b0, irq_out}, 1);
    wr(PND, ONES);
    check("R8 irq lags clear", {31'b0, irq_out}, 1);
    @(negedge clk);
    check("R8 irq dropped", {31'b0, irq_out}, 0);
    set_pins(0); set_pins(32'h40);
    check("R8 irq lags event", {31'b0, irq_out}, 0);
    @(negedge clk);
    check("R8 irq from event", {31'b0, irq_out}, 1);
    wr(PND, ONES); wr(EN, 0);
  endtask

  task automatic t_incapable();
    logic [31:0] v;
    wr(EN, ONES);
    prep(ONES, 0, 0, 0);
    set_pins(32'h4000_0000);
    @(negedge clk);
    rd(PND, v); check("R9 incapable pin edge", v, 0);
    check("R9 incapable pin irq", {31'b0, irq_out}, 0);
    wr(SB, ONES);
    @(negedge clk);
    rd(PND, v); check("R9 incapable pin level", v, 0);
    wr(SB, 0); wr(EN, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_fall();
    t_rise();
    t_both();
    t_level();
    t_w1c();
    t_collide();
    t_irq();
    t_incapable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule